// File: doc/BRIEF.md
# Cascadable Column Sampling Strobe Sequencer

This block produces the one-hot sampling strobes for 240 display column outputs. The outputs are organised as three groups of 80 columns, named A, B and C. A start pulse enters on one of two start pins. A direction input chooses which pin that is. The pulse then walks through a 240-stage shift register, interleaving the groups as A1, B1, C1, A2 and so on, or the reverse of that order. When the pulse leaves the last stage, the block raises a one-period cascade pulse on the opposite start pin, which starts the next driver in a chain.

The three phase inputs are single-cycle strobes, synchronous to the block clock. They stand in for the panel's three shift clocks. In sequential mode each phase advances only the stages of its own slot in the interleave. In single-clock mode, phase 1 alone steps the register. Once the pulse has passed the last stage, the register ignores every phase strobe until a new start pulse arrives. This keeps an idle driver in a cascade from toggling.

Each start pin is split into an input, an output and an output enable. The enable tells the pad whether to drive the pin or to tri-state it.

Top module: `col_strobe_seq`

## Requirements
- R1: After an active-low reset, all strobes are low and both pin outputs are low. Phase strobes alone then move nothing.
- R2: With `dir` = 1, the right pin is the input: `rpin_oe` = 0 and `lpin_oe` = 1. With `dir` = 0 the roles swap. A pin whose enable is low always drives 0 on its output.
- R3: The block captures a start only in a cycle where `ph1` is high and the input pin is high. A start present without `ph1`, or one on the pin configured as output, is ignored.
- R4: With `dir` = 1, scan step k (the first stage is k = 0) raises bus bit (k mod 3)*COLS + k/3. Bits 0..COLS-1 are group A, the next COLS bits are group B, and the last COLS bits are group C.
- R5: With `dir` = 0, scan step k raises the bus bit that scan step 3*COLS-1-k raises under R4, so the order runs C80, B80, A80, C79 and so on.
- R6: With `seq_mode` = 0, each `ph1` strobe advances one stage, and `ph2` and `ph3` have no effect.
- R7: With `seq_mode` = 1, the move away from scan step k happens only on phase ((k+1) mod 3)+1. The other two phases are ignored.
- R8: At most one strobe bit is high in any cycle.
- R9: The advance out of the last stage clears the bus and raises the output-pin cascade level. That level stays high until the next `ph1` strobe, which is exactly one phase-1 period.
- R10: Once the last stage has been left, phase strobes leave the bus at zero until a new start is captured.
- R11: A captured start while the pulse is in flight restarts the scan at step 0. If the start coincides with the exit from the last stage, the cascade pulse is still produced.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low reset |
| dir | input | 1 | Scan direction: 1 selects the right pin as input |
| seq_mode | input | 1 | 1: three-phase sequential stepping; 0: phase 1 only |
| ph1 | input | 1 | Phase 1 strobe; also times start capture and cascade |
| ph2 | input | 1 | Phase 2 strobe |
| ph3 | input | 1 | Phase 3 strobe |
| rpin_in | input | 1 | Right start pin input |
| rpin_out | output | 1 | Right start pin output value |
| rpin_oe | output | 1 | Right start pin drive enable |
| lpin_in | input | 1 | Left start pin input |
| lpin_out | output | 1 | Left start pin output value |
| lpin_oe | output | 1 | Left start pin drive enable |
| strobe | output | 3*COLS | Sampling strobes, group A in the low bits, group C in the high bits |

## Verification
The critical overlap is a new start pulse arriving in the same `ph1` cycle in which the pulse leaves the last stage. The bench provokes it by walking a scan to step 239 and then driving `ph1` together with the start input. The expected result is the first-stage strobe and a raised cascade level in the same sample. On the following `ph1`, the cascade level must drop and the scan must reach step 1.

// File: rtl/col_strobe_seq.sv
module col_strobe_seq #(
  parameter int COLS = 80
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              dir,
  input  logic              seq_mode,
  input  logic              ph1,
  input  logic              ph2,
  input  logic              ph3,
  input  logic              rpin_in,
  output logic              rpin_out,
  output logic              rpin_oe,
  input  logic              lpin_in,
  output logic              lpin_out,
  output logic              lpin_oe,
  output logic [3*COLS-1:0] strobe
);
  localparam int N = 3 * COLS;

  logic [N-1:0] chain;
  logic [1:0]   slot;
  logic         run, cas;

  wire start_in  = dir ? rpin_in : lpin_in;
  wire start_cap = ph1 && start_in;
  wire need      = !seq_mode ? ph1 :
                   (slot == 2'd0) ? ph1 : (slot == 2'd1) ? ph2 : ph3;
  wire adv       = run && need;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain <= '0;
      slot  <= 2'd0;
      run   <= 1'b0;
      cas   <= 1'b0;
    end else begin
      if (ph1) cas <= adv && chain[N-1];
      if (start_cap) begin
        chain <= {{(N-1){1'b0}}, 1'b1};
        slot  <= 2'd1;
        run   <= 1'b1;
      end else if (adv) begin
        chain <= chain << 1;
        slot  <= (slot == 2'd2) ? 2'd0 : slot + 2'd1;
        if (chain[N-1]) run <= 1'b0;
      end
    end
  end

  assign rpin_oe  = !dir;
  assign lpin_oe  = dir;
  assign rpin_out = !dir && cas;
  assign lpin_out = dir && cas;

  for (genvar p = 0; p < N; p++) begin : g_map
    localparam int KF = 3 * (p % COLS) + p / COLS;
    assign strobe[p] = dir ? chain[KF] : chain[N-1-KF];
  end

  // R8
  strobe_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(strobe));

  // R9
  cascade_from_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cas) |-> $past(chain[N-1]));

  // R9
  cascade_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cas && !ph1) |=> cas);

  // R10
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !start_cap) |=> (chain == '0));

  // R3
  start_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_cap |=> (chain[0] && run));
endmodule

// File: tb/test_col_strobe_seq.sv
module test_col_strobe_seq;
  localparam int COLS = 80;
  localparam int N = 3 * COLS;

  logic clk = 0, rst_n = 0, dir = 1, seq_mode = 0;
  logic ph1 = 0, ph2 = 0, ph3 = 0, rpin_in = 0, lpin_in = 0;
  logic rpin_out, rpin_oe, lpin_out, lpin_oe;
  logic [N-1:0] strobe;
  int checks = 0, fails = 0;
  bit done = 0;

  always #5 clk = ~clk;

  col_strobe_seq #(.COLS(COLS)) i_col_strobe_seq (
    .clk(clk), .rst_n(rst_n), .dir(dir), .seq_mode(seq_mode),
    .ph1(ph1), .ph2(ph2), .ph3(ph3),
    .rpin_in(rpin_in), .rpin_out(rpin_out), .rpin_oe(rpin_oe),
    .lpin_in(lpin_in), .lpin_out(lpin_out), .lpin_oe(lpin_oe),
    .strobe(strobe));

  function automatic int phys(int k, logic d);
    int kk = d ? k : N - 1 - k;
    return (kk % 3) * COLS + kk / 3;
  endfunction

  function automatic int idx_of(logic [N-1:0] v);
    for (int i = 0; i < N; i++) if (v[i]) return i;
    return -1;
  endfunction

  task automatic chk(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic chk_pos(int exp, string req);
    logic [N-1:0] e = '0;
    if (exp >= 0) e[exp] = 1'b1;
    chk(strobe == e, req, idx_of(strobe), exp);
  endtask

  task automatic step(logic p1, logic p2, logic p3, logic sr, logic sl);
    ph1 = p1; ph2 = p2; ph3 = p3; rpin_in = sr; lpin_in = sl;
    @(negedge clk);
    ph1 = 0; ph2 = 0; ph3 = 0; rpin_in = 0; lpin_in = 0;
  endtask

  task automatic do_reset();
    rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
  endtask

  task automatic t_reset();
    do_reset();
    chk_pos(-1, "R1 strobes after reset");
    chk(!rpin_out && !lpin_out, "R1 pin outputs after reset", rpin_out + lpin_out, 0);
    step(1, 1, 1, 0, 0);
    step(1, 0, 0, 0, 0);
    chk_pos(-1, "R1 phases move nothing");
  endtask

  task automatic t_pins();
    dir = 1; @(negedge clk);
    chk(!rpin_oe && lpin_oe, "R2 dir=1 enables", {rpin_oe, lpin_oe}, 1);
    chk(!rpin_out, "R2 input pin drives 0", rpin_out, 0);
    dir = 0; @(negedge clk);
    chk(rpin_oe && !lpin_oe, "R2 dir=0 enables", {rpin_oe, lpin_oe}, 2);
    chk(!lpin_out, "R2 input pin drives 0", lpin_out, 0);
  endtask

  task automatic t_ignore();
    do_reset();
    dir = 1; seq_mode = 0;
    step(1, 0, 0, 0, 1);
    chk_pos(-1, "R3 start on output pin ignored");
    step(0, 1, 1, 1, 0);
    chk_pos(-1, "R3 start without ph1 ignored");
  endtask

  task automatic t_fwd();
    do_reset();
    dir = 1; seq_mode = 0;
    step(1, 0, 0, 1, 0);
    chk_pos(phys(0, 1), "R3 R4 start captured");
    for (int k = 1; k < N; k++) begin
      if (k < 6) begin
        step(0, 1, 1, 0, 0);
        chk_pos(phys(k - 1, 1), "R6 ph2/ph3 ignored");
      end
      step(1, 0, 0, 0, 0);
      chk_pos(phys(k, 1), "R4 forward order");
    end
    chk(strobe[N-1], "R4 last stage is C80", idx_of(strobe), N - 1);
    step(1, 0, 0, 0, 0);
    chk_pos(-1, "R9 bus cleared on exit");
    chk(lpin_out && !rpin_out, "R9 cascade on left pin", lpin_out, 1);
    step(0, 1, 1, 0, 0);
    chk(lpin_out, "R9 cascade held until ph1", lpin_out, 1);
    step(1, 0, 0, 0, 0);
    chk(!lpin_out, "R9 cascade drops on next ph1", lpin_out, 0);
    step(1, 1, 1, 0, 0);
    step(1, 0, 0, 0, 0);
    chk_pos(-1, "R10 suspended after exit");
  endtask

  task automatic t_rev();
    do_reset();
    dir = 0; seq_mode = 1;
    step(1, 0, 0, 0, 1);
    chk_pos(phys(0, 0), "R5 start reverse");
    chk(strobe[N-1], "R5 first reverse stage is C80", idx_of(strobe), N - 1);
    for (int k = 1; k < N; k++) begin
      int r = k % 3;
      int w = (r + 1) % 3;
      if (k < 12) begin
        step(w == 0, w == 1, w == 2, 0, 0);
        chk_pos(phys(k - 1, 0), "R7 wrong phase ignored");
      end
      step(r == 0, r == 1, r == 2, 0, 0);
      chk_pos(phys(k, 0), "R5 R7 reverse order");
    end
    chk(strobe[0], "R5 last reverse stage is A1", idx_of(strobe), 0);
    step(0, 1, 1, 0, 0);
    chk_pos(0, "R7 exit waits for ph1");
    step(1, 0, 0, 0, 0);
    chk_pos(-1, "R9 bus cleared on reverse exit");
    chk(rpin_out && !lpin_out, "R9 cascade on right pin", rpin_out, 1);
    step(0, 0, 1, 0, 0);
    chk(rpin_out, "R9 cascade held", rpin_out, 1);
    step(1, 0, 0, 0, 0);
    chk(!rpin_out, "R9 cascade one ph1 period", rpin_out, 0);
    step(0, 1, 0, 0, 0);
    step(0, 0, 1, 0, 0);
    chk_pos(-1, "R10 suspended in sequential mode");
  endtask

  task automatic t_restart();
    do_reset();
    dir = 1; seq_mode = 0;
    step(1, 0, 0, 1, 0);
    for (int k = 0; k < 5; k++) step(1, 0, 0, 0, 0);
    chk_pos(phys(5, 1), "R11 before restart");
    step(1, 0, 0, 1, 0);
    chk_pos(phys(0, 1), "R11 restart mid-scan");
  endtask

  task automatic t_coincide();
    do_reset();
    dir = 1; seq_mode = 0;
    step(1, 0, 0, 1, 0);
    for (int k = 1; k < N; k++) step(1, 0, 0, 0, 0);
    chk_pos(N - 1, "R11 at last stage");
    step(1, 0, 0, 1, 0);
    chk_pos(phys(0, 1), "R11 restart on exit");
    chk(lpin_out, "R11 cascade still produced", lpin_out, 1);
    step(1, 0, 0, 0, 0);
    chk(!lpin_out, "R9 cascade dropped after restart", lpin_out, 0);
    chk_pos(phys(1, 1), "R11 scan continues");
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    t_reset();
    t_pins();
    t_ignore();
    t_fwd();
    t_rev();
    t_restart();
    t_coincide();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule